// File: doc/BRIEF.md
# Inverted Serial Byte Encoder with Clocked-Out Mode

This block carries data bytes from a reader's demodulator to a host microcontroller over one output line, `scio`. Received bytes enter a small FIFO, because they arrive more slowly than the line can send them. The encoder then takes the bytes out of the FIFO one at a time and sends each one in one of two ways.

In the free-running mode, each byte is sent as a fixed-rate frame. The start bit is high, the stop bit is low, and the line rests low between frames. In the clocked mode, the encoder raises `scio` to tell the host that a byte is ready. The host then shifts the byte out itself with falling edges on `shiftClk`.

Bytes from the transponder appear on the line inverted. A separate request inserts a pass/fail diagnostic byte, which is sent exactly as defined, without inversion, and ahead of any queued data.

Top module: `scioByteEncoder`

## Requirements
- R1: In free-running mode a frame is one high start bit, then eight data bits least significant first, then one low stop bit. There is no parity bit.
- R2: Each bit of a free-running frame lasts `BIT_CYCLES` clock cycles (default 1024, which is 64 µs at 16 MHz). The next frame can start no earlier than one cycle after the stop bit ends.
- R3: Every data bit of a byte taken from the FIFO is driven onto `scio` as the complement of the bit written on `byteData`.
- R4: A pulse on `diagReq` queues one diagnostic byte: 0xAF when `diagPass` is 1, 0xFF when it is 0. The byte is sent without inversion. It goes out before any FIFO byte still waiting when the next byte starts.
- R5: The FIFO holds `FIFO_DEPTH` bytes (default 4) and sends them in the order they were written. A write is accepted whenever the FIFO was not full before that clock edge.
- R6: A write into a full FIFO is discarded and sets `overflow`. Once set, `overflow` stays at 1 until reset.
- R7: After reset, `scio` and `overflow` are 0. `scio` stays 0 while no byte is being sent.
- R8: In clocked mode, `scio` goes high in the cycle a byte is taken. Each falling edge of `shiftClk` then places the next data bit on `scio`, least significant first. The new bit appears at the third rising clock edge after the input changes, because the input passes a two-stage synchronizer.
- R9: After the eighth bit, the next rising edge of `shiftClk` returns `scio` low and ends the byte. `shiftClk` edges seen while no byte is pending are ignored.
- R10: If a clocked-mode byte is not finished within `WINDOW_CYCLES` cycles of its ready indication (default 14400, which is 900 µs), it is discarded and `scio` returns low.
- R11: `syncMode` is sampled only when a byte is taken. Changing it while a byte is being sent does not change how that byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Write strobe for a received byte |
| byteData | input | 8 | Received byte, as sent by the transponder |
| syncMode | input | 1 | 0 = free-running frames, 1 = clocked by host |
| shiftClk | input | 1 | Host shift clock for clocked mode (rests high) |
| diagReq | input | 1 | One-cycle request to send the diagnostic byte |
| diagPass | input | 1 | Diagnostic result sampled with `diagReq` |
| scio | output | 1 | Serial line to the host |
| overflow | output | 1 | Sticky flag: a byte was dropped on a full FIFO |

## Verification
The hardest situations to create are a collision between a diagnostic request and queued data in the very cycle the encoder goes idle, and a clocked-mode byte that the host abandons partway through. The bench raises `diagReq` in the same cycle as a byte write, so both are pending when the next byte is taken. It also stops toggling `shiftClk` after three edges and waits past the read window, so the abandon path and the resume that follows both appear on `scio`. A burst of back-to-back writes during a frame fills the FIFO and overflows it.

// File: rtl/scioEncPkg.sv
package scioEncPkg;

  localparam logic [7:0] DIAG_PASS_BYTE = 8'hAF;
  localparam logic [7:0] DIAG_FAIL_BYTE = 8'hFF;
  localparam int         DATA_BITS      = 8;

  // Strobes issued by the control to the datapath in one cycle
  typedef struct packed {
    logic load;       // take the next byte into the shift register
    logic useDiag;    // the byte taken is the diagnostic byte
    logic driveHigh;  // start bit / ready indication
    logic driveBit;   // present shiftReg[0] and shift
    logic driveLow;   // stop level / end of byte
  } encStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASTART,
    ST_ADATA,
    ST_ASTOP,
    ST_SSHIFT,
    ST_SDONE
  } encStateT;

endpackage

// File: rtl/scioEncDatapath.sv
module scioEncDatapath
  import scioEncPkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      byteValid,
  input  logic [7:0] byteData,
  input  logic      diagReq,
  input  logic      diagPass,
  input  encStrobeT stb,
  output logic      fifoEmpty,
  output logic      diagPending,
  output logic      scio,
  output logic      overflow
);

  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(FIFO_DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);

  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, wrEn, popEn;
  logic [7:0]    diagByte;
  logic [7:0]    shiftReg;

  assign full      = (count == FULL_CNT);
  assign fifoEmpty = (count == '0);
  assign wrEn      = byteValid && !full;
  assign popEn     = stb.load && !stb.useDiag;

  // Per-entry storage write
  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wrEn && (wrPtr == AW'(i))) mem[i] <= byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wrEn)  wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popEn) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      unique case ({wrEn, popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (byteValid && full) overflow <= 1'b1;
    end
  end

  // Diagnostic byte holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      diagPending <= 1'b0;
      diagByte    <= DIAG_FAIL_BYTE;
    end else if (diagReq) begin
      diagPending <= 1'b1;
      diagByte    <= diagPass ? DIAG_PASS_BYTE : DIAG_FAIL_BYTE;
    end else if (stb.load && stb.useDiag) begin
      diagPending <= 1'b0;
    end
  end

  // Shift register and line driver
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      scio     <= 1'b0;
    end else begin
      if (stb.load)
        shiftReg <= stb.useDiag ? diagByte : ~mem[rdPtr];
      else if (stb.driveBit)
        shiftReg <= {1'b0, shiftReg[7:1]};

      if (stb.driveHigh)     scio <= 1'b1;
      else if (stb.driveBit) scio <= shiftReg[0];
      else if (stb.driveLow) scio <= 1'b0;
    end
  end

endmodule

// File: rtl/scioEncCtl.sv
module scioEncCtl
  import scioEncPkg::*;
#(
  parameter int BIT_CYCLES    = 1024,
  parameter int WINDOW_CYCLES = 14400
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncMode,
  input  logic      shiftClk,
  input  logic      fifoEmpty,
  input  logic      diagPending,
  output encStrobeT stb
);

  localparam int TW = $clog2(BIT_CYCLES);
  localparam int WW = $clog2(WINDOW_CYCLES);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [TW-1:0] BIT_LAST = TW'(BIT_CYCLES - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYCLES - 1);
  localparam logic [BW-1:0] BIT_MAX  = BW'(DATA_BITS - 1);

  encStateT      state, nState;
  logic [TW-1:0] timer, nTimer;
  logic [WW-1:0] winCnt, nWin;
  logic [BW-1:0] bitCnt, nBit;
  logic [2:0]    clkSync;
  logic          fallSeen, riseSeen, bitDone, winDone, haveByte;

  // Two-stage synchronizer plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) clkSync <= 3'b111;
    else       clkSync <= {clkSync[1:0], shiftClk};
  end

  assign fallSeen = clkSync[2] & ~clkSync[1];
  assign riseSeen = ~clkSync[2] & clkSync[1];
  assign bitDone  = (timer == BIT_LAST);
  assign winDone  = (winCnt == WIN_LAST);
  assign haveByte = diagPending || !fifoEmpty;

  always_comb begin
    stb    = '0;
    nState = state;
    nTimer = timer + 1'b1;
    nWin   = winCnt + 1'b1;
    nBit   = bitCnt;
    unique case (state)
      ST_IDLE: begin
        nTimer = '0;
        nWin   = '0;
        nBit   = '0;
        if (haveByte) begin
          stb.load      = 1'b1;
          stb.useDiag   = diagPending;
          stb.driveHigh = 1'b1;
          nState        = syncMode ? ST_SSHIFT : ST_ASTART;
        end
      end
      ST_ASTART: begin
        if (bitDone) begin
          nTimer       = '0;
          stb.driveBit = 1'b1;
          nState       = ST_ADATA;
        end
      end
      ST_ADATA: begin
        if (bitDone) begin
          nTimer = '0;
          if (bitCnt == BIT_MAX) begin
            stb.driveLow = 1'b1;
            nState       = ST_ASTOP;
          end else begin
            stb.driveBit = 1'b1;
            nBit         = bitCnt + 1'b1;
          end
        end
      end
      ST_ASTOP: begin
        if (bitDone) begin
          nTimer = '0;
          nState = ST_IDLE;
        end
      end
      ST_SSHIFT: begin
        if (winDone) begin
          stb.driveLow = 1'b1;
          nState       = ST_IDLE;
        end else if (fallSeen) begin
          stb.driveBit = 1'b1;
          nBit         = bitCnt + 1'b1;
          if (bitCnt == BIT_MAX) nState = ST_SDONE;
        end
      end
      ST_SDONE: begin
        if (winDone || riseSeen) begin
          stb.driveLow = 1'b1;
          nState       = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      winCnt <= '0;
      bitCnt <= '0;
    end else begin
      state  <= nState;
      timer  <= nTimer;
      winCnt <= nWin;
      bitCnt <= nBit;
    end
  end

endmodule

// File: rtl/scioByteEncoder.sv
module scioByteEncoder
  import scioEncPkg::*;
#(
  parameter int BIT_CYCLES    = 1024,
  parameter int WINDOW_CYCLES = 14400,
  parameter int FIFO_DEPTH    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       syncMode,
  input  logic       shiftClk,
  input  logic       diagReq,
  input  logic       diagPass,
  output logic       scio,
  output logic       overflow
);

  encStrobeT stb;
  logic      fifoEmpty;
  logic      diagPending;

  scioEncCtl #(
    .BIT_CYCLES   (BIT_CYCLES),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .syncMode   (syncMode),
    .shiftClk   (shiftClk),
    .fifoEmpty  (fifoEmpty),
    .diagPending(diagPending),
    .stb        (stb)
  );

  scioEncDatapath #(
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .diagReq    (diagReq),
    .diagPass   (diagPass),
    .stb        (stb),
    .fifoEmpty  (fifoEmpty),
    .diagPending(diagPending),
    .scio       (scio),
    .overflow   (overflow)
  );

endmodule

// File: rtl/scioEncChecker.sv
module scioEncChecker
  import scioEncPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      byteValid,
  input logic      overflow,
  input logic      scio,
  input encStrobeT stb,
  input logic      fifoEmpty,
  input logic      diagPending
);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R6
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(byteValid));

  // R5
  fifo_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.useDiag) |-> !fifoEmpty);

  // R4
  diag_take_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.useDiag) |-> diagPending);

  // R1
  line_drive_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.driveHigh, stb.driveBit, stb.driveLow}));

  // R7
  scio_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scio) |-> $past(stb.driveHigh || stb.driveBit));

endmodule

bind scioByteEncoder scioEncChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .byteValid  (byteValid),
  .overflow   (overflow),
  .scio       (scio),
  .stb        (stb),
  .fifoEmpty  (fifoEmpty),
  .diagPending(diagPending)
);

// File: tb/scioByteEncoder_test.sv
`timescale 1ns/1ps
module scioByteEncoder_test;

  localparam int BITC  = 8;
  localparam int WIN   = 200;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       syncMode = 1'b0;
  logic       shiftClk = 1'b1;
  logic       diagReq = 1'b0;
  logic       diagPass = 1'b0;
  logic       scio;
  logic       overflow;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R7";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  scioByteEncoder #(
    .BIT_CYCLES(BITC), .WINDOW_CYCLES(WIN), .FIFO_DEPTH(DEPTH)
  ) uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .syncMode(syncMode), .shiftClk(shiftClk), .diagReq(diagReq),
    .diagPass(diagPass), .scio(scio), .overflow(overflow)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] q[$];
  bit         mPend;
  logic [7:0] mDiag;
  int         ph, tmr, nb, win;
  logic [7:0] sh;
  bit         expScio, expOvf;
  bit         d1, d2, d3;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      mPend = 0; mDiag = 8'hFF; ph = 0; tmr = 0; nb = 0; win = 0;
      sh = '0; expScio = 0; expOvf = 0; d1 = 1; d2 = 1; d3 = 1;
    end else begin
      bit fallNow, riseNow, wasFull;
      fallNow = d3 && !d2;
      riseNow = !d3 && d2;
      d3 = d2; d2 = d1; d1 = shiftClk;
      wasFull = (q.size() == DEPTH);
      case (ph)
        0: begin
          tmr = 0; nb = 0; win = 0;
          if (mPend || q.size() > 0) begin
            if (mPend) begin sh = mDiag; mPend = 0; end
            else sh = ~q.pop_front();
            expScio = 1;
            ph = syncMode ? 4 : 1;
          end
        end
        1: if (tmr == BITC-1) begin tmr = 0; expScio = sh[0]; sh = sh >> 1; ph = 2; end
           else tmr++;
        2: if (tmr == BITC-1) begin
             tmr = 0;
             if (nb == 7) begin expScio = 0; ph = 3; end
             else begin expScio = sh[0]; sh = sh >> 1; nb++; end
           end else tmr++;
        3: if (tmr == BITC-1) begin tmr = 0; ph = 0; end else tmr++;
        4: if (win == WIN-1) begin expScio = 0; ph = 0; end
           else begin
             win++;
             if (fallNow) begin
               expScio = sh[0]; sh = sh >> 1;
               if (nb == 7) ph = 5;
               nb++;
             end
           end
        5: if (win == WIN-1 || riseNow) begin expScio = 0; ph = 0; end
           else win++;
        default: ph = 0;
      endcase
      if (diagReq) begin mPend = 1; mDiag = diagPass ? 8'hAF : 8'hFF; end
      if (byteValid) begin
        if (wasFull) expOvf = 1;
        else q.push_back(byteData);
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (scio !== expScio || overflow !== expOvf) begin
        fails++;
        $display("FAIL %s t=%0t scio/overflow actual=%b/%b expected=%b/%b",
                 curReq, $time, scio, overflow, expScio, expOvf);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1; byteData = b;
    @(negedge clk); byteValid = 0;
  endtask

  task automatic pulseFalls(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); shiftClk = 0;
      waitCycles(half);
      shiftClk = 1;
      waitCycles(half);
    end
  endtask

  task automatic portCheck(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    waitCycles(5);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // R7 reset state at the ports
    portCheck("R7 reset scio", scio, 1'b0);
    portCheck("R7 reset overflow", overflow, 1'b0);
    waitCycles(10);

    // R1 R2 R3: free-running frames of transponder bytes
    curReq = "R1 R2 R3";
    pushByte(8'h5A);
    waitCycles(95);
    pushByte(8'h81);
    pushByte(8'h01);
    waitCycles(190);

    // R4: diagnostic pass request together with a data byte
    curReq = "R4";
    @(negedge clk); byteValid = 1; byteData = 8'h11; diagReq = 1; diagPass = 1;
    @(negedge clk); byteValid = 0; diagReq = 0;
    waitCycles(190);
    @(negedge clk); diagReq = 1; diagPass = 0;
    @(negedge clk); diagReq = 0;
    waitCycles(100);

    // R5 R6: burst fills the FIFO and overflows it
    curReq = "R5 R6";
    portCheck("R6 no overflow before burst", overflow, 1'b0);
    for (int i = 0; i < 7; i++) pushByte(8'h30 + 8'(i));
    portCheck("R6 overflow after burst", overflow, 1'b1);
    waitCycles(520);
    portCheck("R6 overflow sticky", overflow, 1'b1);
    portCheck("R7 idle line low", scio, 1'b0);

    // R8 R9: clocked mode
    curReq = "R8 R9";
    syncMode = 1;
    pushByte(8'h3C);
    waitCycles(6);
    pulseFalls(8, 4);
    waitCycles(10);
    curReq = "R9";
    pulseFalls(3, 4);
    waitCycles(10);
    portCheck("R9 edges ignored while idle", scio, 1'b0);

    // R10: host abandons the byte
    curReq = "R10";
    pushByte(8'hC5);
    pulseFalls(3, 4);
    waitCycles(WIN + 20);
    portCheck("R10 line low after window", scio, 1'b0);
    pushByte(8'h96);
    waitCycles(4);
    pulseFalls(8, 3);
    waitCycles(10);

    // R11: mode changes mid-byte have no effect on that byte
    curReq = "R11";
    pushByte(8'h6B);
    waitCycles(3);
    syncMode = 0;
    pulseFalls(8, 4);
    waitCycles(10);
    pushByte(8'hE7);
    waitCycles(3);
    syncMode = 1;
    pulseFalls(4, 4);
    waitCycles(90);

    finishRun();
  end

endmodule